// File: doc/BRIEF.md
# Quad-Accumulator Multiply-Accumulate Engine

This block is the arithmetic back end of a small processor's multiply-accumulate path. Each cycle it can accept one operation: two 32-bit operands and a command. The command picks the operand format, whether the product is added or subtracted, and which of four 48-bit accumulators receives it. The product then passes through a fixed four-stage pipeline: operand capture, multiply, scale and sign, and accumulate. Each accumulator keeps a sticky overflow flag. A saturate input, sampled when an operation retires, decides whether an overflowing result wraps or clamps.

Software-visible state is reached through a simple register-style port. A direct write loads an accumulator and clears its flag. A read request goes to a small controller with three states. READ_IDLE takes the request and moves to READ_HOLD, where it counts down the operations aimed at the same accumulator that are older than the request. When the count reaches zero it moves to READ_SHOW, which presents the value and flag for one cycle and returns to READ_IDLE. So a read never returns a value that an earlier operation is still about to change.

Top module: `mac_quad_acc`

## Requirements
- R1: An operation accepted on clock edge k updates its accumulator on edge k+3. A read issued on edge k+3 therefore returns the new value with latency 1, and a read issued on edge k+2 has latency 2. Latency is the number of edges from the request edge to the edge after which rd_valid is high.
- R2: op_mode 2'b00 (and 2'b11) selects signed integer operands; a 32-bit operand is sign-extended.
- R3: op_mode 2'b01 selects unsigned integer operands; a 32-bit operand is zero-extended.
- R4: With op_half=1 each operand is a 16-bit halfword: bits [31:16] when its op_a_hi / op_b_hi bit is 1, otherwise bits [15:0]. It is extended according to op_mode.
- R5: op_mode 2'b10 is signed fractional: the signed product is shifted left by one bit before it is accumulated.
- R6: op_sub=1 subtracts the product from the accumulator; op_sub=0 adds it.
- R7: A read is taken only when rd_ready is 1. When no older operation targets the read accumulator, rd_valid rises one edge after the request. An operation to the same accumulator accepted on the request edge delays rd_valid to four edges after the request, and the value returned includes that operation. An operation to a different accumulator causes no delay.
- R8: When the true sum leaves the signed 48-bit range and sat_en=0, the accumulator keeps the low 48 bits of the sum and its bit in ovf_flags (bit n for accumulator n) is set. The bit stays set through later non-overflowing operations.
- R9: When the true sum overflows with sat_en=1, the accumulator is clamped to 0x7FFF_FFFF_FFFF (positive overflow) or 0x8000_0000_0000 (negative overflow), and its flag is set.
- R10: A direct write (wr_en) loads wr_data into accumulator wr_sel and clears its flag. If an operation retires into the same accumulator on the same edge, the write wins.
- R11: After reset all accumulators read zero, ovf_flags is zero, rd_ready is 1 and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_mode | input | 2 | 00 signed int, 01 unsigned int, 10 signed fractional, 11 signed int |
| op_half | input | 1 | 1 = halfword operands |
| op_a_hi | input | 1 | Upper halfword of op_a when op_half=1 |
| op_b_hi | input | 1 | Upper halfword of op_b when op_half=1 |
| op_sub | input | 1 | 1 = subtract the product |
| op_acc | input | 2 | Target accumulator |
| sat_en | input | 1 | Clamp instead of wrap on overflow |
| wr_en | input | 1 | Direct accumulator write |
| wr_sel | input | 2 | Accumulator to write |
| wr_data | input | 48 | Value to write |
| rd_req | input | 1 | Read request (taken when rd_ready) |
| rd_sel | input | 2 | Accumulator to read |
| rd_ready | output | 1 | Read controller is idle |
| rd_valid | output | 1 | One-cycle pulse with the read result |
| rd_data | output | 48 | Accumulator value read |
| rd_ovf | output | 1 | Overflow flag of the accumulator read |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
Every cycle, the assertions check that rd_valid is a single-cycle pulse and that a taken request drops rd_ready. They also check that an overflow flag stays set until a direct write to its own accumulator, and that a saturating overflow leaves the accumulator at one of the two extreme values. Only the directed scenarios can show the arithmetic: the operand extension for each mode, the halfword selection, the fractional shift, and the add and subtract signs. The scenarios also cover the exact read latency with and without a pending operation, the write-over-retire priority, and the wrapped values.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        MODE_SINT  = 2'b00,
        MODE_UINT  = 2'b01,
        MODE_SFRAC = 2'b10,
        MODE_ALT   = 2'b11
    } mac_mode_e;

    typedef enum logic [1:0] {
        READ_IDLE,
        READ_HOLD,
        READ_SHOW
    } rd_state_e;
endpackage

// File: rtl/mac_opnd_fmt.sv
module mac_opnd_fmt #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   raw,
    input  logic              half,
    input  logic              hi,
    input  logic              sgn,
    output logic signed [OP_W:0] ext
);
    localparam int HW = OP_W / 2;
    logic [HW-1:0] hword;

    always_comb begin
        hword = hi ? raw[OP_W-1:HW] : raw[HW-1:0];
        if (half)
            ext = sgn ? {{(OP_W-HW+1){hword[HW-1]}}, hword}
                      : {{(OP_W-HW+1){1'b0}}, hword};
        else
            ext = {sgn & raw[OP_W-1], raw};
    end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
    parameter int ACC_W = 48,
    parameter int N_ACC = 4,
    parameter int SUM_W = 68,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ret_v,
    input  logic [SEL_W-1:0]        ret_sel,
    input  logic signed [SUM_W-1:0] ret_add,
    input  logic                    sat_en,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [ACC_W-1:0]        wr_data,
    input  logic [SEL_W-1:0]        rd_sel,
    output logic [ACC_W-1:0]        rd_val,
    output logic                    rd_ovf,
    output logic [N_ACC-1:0]        ovf_flags
);
    localparam logic signed [SUM_W-1:0] MAX_S =
        $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] MIN_S =
        $signed({{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});
    localparam logic [ACC_W-1:0] MAX_A = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_A = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0]        acc_q [N_ACC];
    logic                    ovf_q [N_ACC];
    logic [ACC_W-1:0]        cur;
    logic signed [SUM_W-1:0] sum;
    logic                    ret_ovf;
    logic [ACC_W-1:0]        res;

    always_comb begin
        cur     = acc_q[ret_sel];
        sum     = $signed({{(SUM_W-ACC_W){cur[ACC_W-1]}}, cur}) + ret_add;
        ret_ovf = (sum > MAX_S) || (sum < MIN_S);
        if (ret_ovf && sat_en)
            res = sum[SUM_W-1] ? MIN_A : MAX_A;
        else
            res = sum[ACC_W-1:0];
    end

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
                ovf_q[i] <= 1'b0;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                acc_q[i] <= wr_data;
                ovf_q[i] <= 1'b0;
            end else if (ret_v && ret_sel == SEL_W'(i)) begin
                acc_q[i] <= res;
                if (ret_ovf) ovf_q[i] <= 1'b1;
            end
        end
        assign ovf_flags[i] = ovf_q[i];

        // R8
        sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !(wr_en && wr_sel == SEL_W'(i))) |=> ovf_q[i]);
    end

    assign rd_val = acc_q[rd_sel];
    assign rd_ovf = ovf_q[rd_sel];

    // R9
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_v && sat_en && ret_ovf && !(wr_en && wr_sel == ret_sel))
        |=> (acc_q[$past(ret_sel)] == MAX_A || acc_q[$past(ret_sel)] == MIN_A));
endmodule

// File: rtl/mac_quad_acc.sv
module mac_quad_acc #(
    parameter int OP_W  = 32,
    parameter int ACC_W = 48,
    parameter int N_ACC = 4,
    localparam int SEL_W = $clog2(N_ACC),
    localparam int PW    = 2 * (OP_W + 1),
    localparam int SUM_W = PW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [1:0]       op_mode,
    input  logic             op_half,
    input  logic             op_a_hi,
    input  logic             op_b_hi,
    input  logic             op_sub,
    input  logic [SEL_W-1:0] op_acc,
    input  logic             sat_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             rd_req,
    input  logic [SEL_W-1:0] rd_sel,
    output logic             rd_ready,
    output logic             rd_valid,
    output logic [ACC_W-1:0] rd_data,
    output logic             rd_ovf,
    output logic [N_ACC-1:0] ovf_flags
);
    import mac_pkg::*;

    mac_mode_e mode;
    logic      sgn, frac;
    logic signed [OP_W:0] ea, eb;

    assign mode = mac_mode_e'(op_mode);
    assign sgn  = (mode != MODE_UINT);
    assign frac = (mode == MODE_SFRAC);

    mac_opnd_fmt #(.OP_W(OP_W)) u_fmt_a (.raw(op_a), .half(op_half), .hi(op_a_hi), .sgn(sgn), .ext(ea));
    mac_opnd_fmt #(.OP_W(OP_W)) u_fmt_b (.raw(op_b), .half(op_half), .hi(op_b_hi), .sgn(sgn), .ext(eb));

    // stage 1: captured operands; stage 2: product; stage 3: scaled addend
    logic                    s1_v, s2_v, s3_v;
    logic                    s1_frac, s2_frac, s1_sub, s2_sub;
    logic [SEL_W-1:0]        s1_acc, s2_acc, s3_acc;
    logic signed [OP_W:0]    s1_a, s1_b;
    logic signed [PW-1:0]    s2_prod;
    logic signed [SUM_W-1:0] widen, s3_add;

    always_comb begin
        widen = $signed({{(SUM_W-PW){s2_prod[PW-1]}}, s2_prod});
        if (s2_frac) widen = widen <<< 1;
        if (s2_sub)  widen = -widen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0;
            s1_frac <= 1'b0; s2_frac <= 1'b0; s1_sub <= 1'b0; s2_sub <= 1'b0;
            s1_acc <= '0; s2_acc <= '0; s3_acc <= '0;
            s1_a <= '0; s1_b <= '0; s2_prod <= '0; s3_add <= '0;
        end else begin
            s1_v <= op_valid; s1_a <= ea; s1_b <= eb;
            s1_frac <= frac; s1_sub <= op_sub; s1_acc <= op_acc;
            s2_v <= s1_v; s2_prod <= s1_a * s1_b;
            s2_frac <= s1_frac; s2_sub <= s1_sub; s2_acc <= s1_acc;
            s3_v <= s2_v; s3_add <= widen; s3_acc <= s2_acc;
        end
    end

    logic [ACC_W-1:0] bk_val;
    logic             bk_ovf;
    logic [SEL_W-1:0] rsel_q;

    mac_acc_bank #(.ACC_W(ACC_W), .N_ACC(N_ACC), .SUM_W(SUM_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ret_v(s3_v), .ret_sel(s3_acc), .ret_add(s3_add), .sat_en(sat_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rsel_q), .rd_val(bk_val), .rd_ovf(bk_ovf), .ovf_flags(ovf_flags));

    // read controller: hold count = depth of youngest older op to the same accumulator
    rd_state_e        st_q, st_d;
    logic [1:0]       cnt_q, cnt_d, dep;
    logic [ACC_W-1:0] rd_data_q;
    logic             rd_ovf_q;

    always_comb begin
        if (op_valid && op_acc == rd_sel)  dep = 2'd3;
        else if (s1_v && s1_acc == rd_sel) dep = 2'd2;
        else if (s2_v && s2_acc == rd_sel) dep = 2'd1;
        else                               dep = 2'd0;
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            READ_IDLE: if (rd_req) begin st_d = READ_HOLD; cnt_d = dep; end
            READ_HOLD: if (cnt_q == 2'd0) st_d = READ_SHOW;
                       else cnt_d = cnt_q - 2'd1;
            READ_SHOW: st_d = READ_IDLE;
            default:   st_d = READ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= READ_IDLE; cnt_q <= '0; rsel_q <= '0;
            rd_data_q <= '0; rd_ovf_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == READ_IDLE && rd_req) rsel_q <= rd_sel;
            if (st_q == READ_HOLD && cnt_q == 2'd0) begin
                rd_data_q <= bk_val;
                rd_ovf_q  <= bk_ovf;
            end
        end
    end

    always_comb begin
        rd_ready = (st_q == READ_IDLE);
        rd_valid = (st_q == READ_SHOW);
    end
    assign rd_data = rd_data_q;
    assign rd_ovf  = rd_ovf_q;

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R7
    rd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> !rd_ready);
endmodule

// File: tb/mac_quad_acc_tb_top.sv
`timescale 1ns/1ps
module mac_quad_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 0, op_half = 0, op_a_hi = 0, op_b_hi = 0, op_sub = 0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  op_mode = '0, op_acc = '0, wr_sel = '0, rd_sel = '0;
    logic        sat_en = 0, wr_en = 0, rd_req = 0;
    logic [47:0] wr_data = '0;
    logic        rd_ready, rd_valid, rd_ovf;
    logic [47:0] rd_data;
    logic [3:0]  ovf_flags;

    int total = 0, bad = 0;
    logic [47:0] d;
    logic        f;
    int          lat;

    always #2.5 clk = ~clk;

    mac_quad_acc dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op_fields(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                             input logic h, input logic ah, input logic bh,
                             input logic s, input logic [1:0] acc);
        op_a = a; op_b = b; op_mode = m; op_half = h;
        op_a_hi = ah; op_b_hi = bh; op_sub = s; op_acc = acc;
    endtask

    task automatic step_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                           input logic h, input logic ah, input logic bh,
                           input logic s, input logic [1:0] acc);
        @(negedge clk);
        op_fields(a, b, m, h, ah, bh, s, acc);
        op_valid = 1;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic acc_write(input logic [1:0] sel, input logic [47:0] v);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    // fire=1 offers the preset op fields on the same edge as the request
    task automatic acc_read(input logic [1:0] sel, input logic fire);
        @(negedge clk);
        rd_req = 1; rd_sel = sel; op_valid = fire;
        @(negedge clk);
        rd_req = 0; op_valid = 0;
        lat = 0;
        while (!rd_valid) begin
            @(negedge clk);
            lat++;
        end
        d = rd_data; f = rd_ovf;
    endtask

    task automatic t_reset;
        chk("R11 rd_ready", 64'(rd_ready), 64'd1);
        chk("R11 rd_valid", 64'(rd_valid), 64'd0);
        chk("R11 ovf_flags", 64'(ovf_flags), 64'd0);
        for (int i = 0; i < 4; i++) begin
            acc_read(2'(i), 0);
            chk("R11 acc zero", 64'(d), 64'd0);
        end
    endtask

    task automatic t_latency;
        step_op(32'd6, 32'd7, 2'b00, 0, 0, 0, 0, 2'd0);
        @(negedge clk);
        acc_read(2'd0, 0);
        chk("R1 latency at k+3", 64'(lat), 64'd1);
        chk("R1 value", 64'(d), 64'd42);
        step_op(32'd1, 32'd8, 2'b00, 0, 0, 0, 0, 2'd0);
        acc_read(2'd0, 0);
        chk("R1 latency at k+2", 64'(lat), 64'd2);
        chk("R1 value2", 64'(d), 64'd50);
    endtask

    task automatic t_signed;
        longint e;
        acc_write(2'd1, '0);
        step_op(32'hFFFF_FFFD, 32'd7, 2'b00, 0, 0, 0, 0, 2'd1);
        step_op(32'd100000, -32'sd300000, 2'b11, 0, 0, 0, 0, 2'd1);
        e = -64'sd21 - 64'sd30000000000;
        acc_read(2'd1, 0);
        chk("R2 signed int32", 64'(d), 64'(e[47:0]));
    endtask

    task automatic t_unsigned;
        acc_write(2'd2, '0);
        acc_write(2'd3, '0);
        step_op(32'hFFFF_FFFF, 32'd2, 2'b01, 0, 0, 0, 0, 2'd2);
        step_op(32'hFFFF_FFFF, 32'd2, 2'b00, 0, 0, 0, 0, 2'd3);
        acc_read(2'd2, 0);
        chk("R3 unsigned int32", 64'(d), 64'h1_FFFF_FFFE);
        acc_read(2'd3, 0);
        chk("R2 same bits signed", 64'(d), 64'hFFFF_FFFF_FFFE);
    endtask

    task automatic t_half;
        acc_write(2'd1, '0);
        acc_write(2'd2, '0);
        step_op(32'h1234_FFFE, 32'h0005_7777, 2'b00, 1, 0, 1, 0, 2'd1);
        step_op(32'h1234_FFFE, 32'h0005_7777, 2'b01, 1, 0, 1, 0, 2'd2);
        acc_read(2'd1, 0);
        chk("R4 signed half lo*hi", 64'(d), 64'hFFFF_FFFF_FFF6);
        acc_read(2'd2, 0);
        chk("R4 unsigned half lo*hi", 64'(d), 64'd327670);
    endtask

    task automatic t_frac;
        acc_write(2'd3, '0);
        step_op(32'h0000_4000, 32'h4000_0000, 2'b10, 1, 0, 1, 0, 2'd3);
        acc_read(2'd3, 0);
        chk("R5 frac half 0.5*0.5", 64'(d), 64'h2000_0000);
        step_op(32'h8000_0000, 32'h0000_8000, 2'b10, 1, 1, 0, 0, 2'd3);
        step_op(32'd3, 32'd5, 2'b10, 0, 0, 0, 0, 2'd3);
        acc_read(2'd3, 0);
        chk("R5 frac -1*-1 and full", 64'(d), 64'hA000_0000 + 64'd30);
    endtask

    task automatic t_sub;
        acc_write(2'd0, 48'd100);
        step_op(32'd3, 32'd4, 2'b00, 0, 0, 0, 1, 2'd0);
        acc_read(2'd0, 0);
        chk("R6 subtract", 64'(d), 64'd88);
        step_op(-32'sd5, 32'd6, 2'b00, 0, 0, 0, 1, 2'd0);
        acc_read(2'd0, 0);
        chk("R6 subtract negative", 64'(d), 64'd118);
    endtask

    task automatic t_interlock;
        acc_write(2'd1, '0);
        op_fields(32'd2, 32'd3, 2'b00, 0, 0, 0, 0, 2'd1);
        acc_read(2'd1, 1);
        chk("R7 same acc stall", 64'(lat), 64'd4);
        chk("R7 same acc value", 64'(d), 64'd6);
        op_fields(32'd2, 32'd3, 2'b00, 0, 0, 0, 0, 2'd1);
        acc_read(2'd2, 1);
        chk("R7 other acc no stall", 64'(lat), 64'd1);
        acc_read(2'd1, 0);
        chk("R7 other acc op landed", 64'(d), 64'd12);
    endtask

    task automatic t_wrap;
        sat_en = 0;
        acc_write(2'd2, 48'h7FFF_FFFF_FFF0);
        step_op(32'h100, 32'd1, 2'b00, 0, 0, 0, 0, 2'd2);
        acc_read(2'd2, 0);
        chk("R8 wrap value", 64'(d), 64'h8000_0000_00F0);
        chk("R8 rd_ovf", 64'(f), 64'd1);
        chk("R8 flag bit2", 64'(ovf_flags), 64'b0100);
        step_op(32'd1, 32'd1, 2'b00, 0, 0, 0, 0, 2'd2);
        acc_read(2'd2, 0);
        chk("R8 after wrap add", 64'(d), 64'h8000_0000_00F1);
        chk("R8 sticky", 64'(ovf_flags[2]), 64'd1);
    endtask

    task automatic t_sat;
        @(negedge clk); sat_en = 1;
        acc_write(2'd3, 48'h7FFF_FFFF_FFF0);
        step_op(32'h100, 32'd1, 2'b00, 0, 0, 0, 0, 2'd3);
        acc_read(2'd3, 0);
        chk("R9 clamp high", 64'(d), 64'h7FFF_FFFF_FFFF);
        chk("R9 flag", 64'(ovf_flags[3]), 64'd1);
        acc_write(2'd3, 48'h8000_0000_0010);
        chk("R10 write clears flag", 64'(ovf_flags[3]), 64'd0);
        step_op(32'h100, 32'd1, 2'b00, 0, 0, 0, 1, 2'd3);
        acc_read(2'd3, 0);
        chk("R9 clamp low", 64'(d), 64'h8000_0000_0000);
        chk("R9 flag low", 64'(f), 64'd1);
        @(negedge clk); sat_en = 0;
    endtask

    task automatic t_write;
        acc_write(2'd2, 48'd5);
        chk("R10 flag cleared", 64'(ovf_flags[2]), 64'd0);
        acc_read(2'd2, 0);
        chk("R10 write value", 64'(d), 64'd5);
        @(negedge clk);
        op_fields(32'd9, 32'd9, 2'b00, 0, 0, 0, 0, 2'd1);
        op_valid = 1;
        @(negedge clk);
        op_valid = 0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd1; wr_data = 48'd77;
        @(negedge clk);
        wr_en = 0;
        acc_read(2'd1, 0);
        chk("R10 write beats retire", 64'(d), 64'd77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_signed();
        t_unsigned();
        t_half();
        t_frac();
        t_sub();
        t_interlock();
        t_wrap();
        t_sat();
        t_write();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule